// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time and Fault Shutdown

The block turns a shared free-running up-counter into two complementary pin-level PWM signals. The counter is compared against a duty value to form an edge-aligned reference. The reference then feeds three stages in turn. The first inserts a programmable dead-time gap, with a prescaler, between the two halves of the pair. The second applies a pair swap and per-channel software override. The third applies per-channel masking, fault shutdown and an output level selection. Both pins come out of registers.

Up to four fault inputs are qualified by an enable, an active level and a choice between a direct and a filtered path. A fault drives the affected channels to their inactive level at once and sets a sticky flag. The affected channels depend on the fault mode: none, the even channel only, or both. Outputs come back at a counter wrap. In automatic mode they return as soon as the fault is gone. In manual mode they return only once the flag has also been cleared.

Top module: `cpwm_pair`

## Requirements
- R1: The counter runs 0 to period-1. The internal reference is active while cnt_val < duty. With no dead time, high-true level and no overrides, pin_hi is high for duty cycles of every period and pin_lo for the remaining period-duty cycles.
- R2: A duty of 0 keeps pin_hi inactive for the whole period. A duty equal to or above the period keeps it active for the whole period.
- R3: Every reference edge starts a dead-time gap of dt_cnt × scale cycles, during which both channels are inactive. scale is 1 for dt_pre=0, 4 for dt_pre=1 and 16 for dt_pre=2 or 3. dt_cnt is 10 bits wide (0 to 1023). With high-true level and no software override, the two pins are never high together.
- R4: If the reference changes again inside a gap, the gap restarts, so a pulse no longer than the gap never appears.
- R5: out_lvl selects the level. 2 is high-true (pin = active). 1 is low-true (pin = not active). 0 or 3 means no output, and both pins stay 0.
- R6: With pair_inv=1 the two channel signals are exchanged before the override stages.
- R7: When sw_en[i] is 1, channel i (0 is pin_hi, 1 is pin_lo) takes sw_val[i] in place of the PWM signal.
- R8: When mask[i] is 1, channel i is inactive, whatever the PWM or software value.
- R9: flt_mode 2 (manual, both channels). An asserted fault makes both channels inactive from the next cycle and sets fault_flag. A flt_clr pulse clears the flag only while no fault is present. Outputs resume at the first wrap (cnt_val = period-1) after the flag is clear.
- R10: flt_mode 3 (automatic, both channels). Outputs resume at the first wrap with no fault present. fault_flag stays set until flt_clr.
- R11: flt_mode 1 (manual, even channel). A fault shuts down only channel 0 (pin_hi). pin_lo keeps running.
- R12: flt_mode 0 disables fault control, and the flag is not set. An input with flt_en[i]=0 is ignored in every mode.
- R13: With flt_lowact[i]=1, a 0 on flt_in[i] is a fault and a 1 is not.
- R14: With flt_use_filt[i]=1, an input change takes effect only after it has held steady for more than flt_len cycles. A shorter pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Shared counter value |
| period | input | CW | Counter period in ticks |
| duty | input | CW | Duty in ticks |
| dt_pre | input | 2 | Dead-time scale select |
| dt_cnt | input | DTW | Dead-time count |
| out_lvl | input | 2 | Output level select |
| pair_inv | input | 1 | Swap the pair |
| sw_en | input | 2 | Software override enable per channel |
| sw_val | input | 2 | Software override value per channel |
| mask | input | 2 | Per-channel mask |
| flt_mode | input | 2 | Fault mode |
| flt_en | input | NFLT | Fault input enables |
| flt_lowact | input | NFLT | Fault active-low select |
| flt_use_filt | input | NFLT | Filtered path select |
| flt_len | input | FLW | Filter length |
| flt_in | input | NFLT | Fault inputs |
| flt_clr | input | 1 | Fault flag clear pulse |
| pin_hi | output | 1 | Channel 0 pin |
| pin_lo | output | 1 | Channel 1 pin |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
Four properties are checked on every cycle. The pins must never be high together in high-true operation. A masked or level-off channel must stay at its forced value. A direct-path fault must set the flag and blank both pins one cycle later. The flag must persist until a clear. The bench alone shows the dead-time widths under each prescale, the suppression of short pulses, and resume timing in the manual and automatic modes. It also shows the filter rejecting short glitches and the even-only shutdown, all measured as per-period active counts.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_RSV  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    FM_OFF      = 2'd0,
    FM_EVEN_MAN = 2'd1,
    FM_ALL_MAN  = 2'd2,
    FM_ALL_AUTO = 2'd3
  } fmode_e;

  function automatic logic [2:0] dt_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DTW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_in,
  input  logic [1:0]     dt_pre,
  input  logic [DTW-1:0] dt_cnt,
  output logic           act_a,
  output logic           act_b
);
  import cpwm_pkg::*;
  localparam int TW = DTW + 4;

  logic          ref_q, ref_n;
  logic [TW-1:0] gap_q, gap_n, span;

  always_comb begin
    span  = TW'(dt_cnt) << dt_shift(dt_pre);
    ref_n = ref_q;
    gap_n = gap_q;
    if (ref_in != ref_q) begin
      ref_n = ref_in;
      gap_n = span;
    end else if (gap_q != '0) begin
      gap_n = gap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      gap_q <= '0;
    end else begin
      ref_q <= ref_n;
      gap_q <= gap_n;
    end
  end

  assign act_a = ref_q & (gap_q == '0);
  assign act_b = ~ref_q & (gap_q == '0);
endmodule

// File: rtl/cpwm_flt_filter.sv
module cpwm_flt_filter #(
  parameter int FLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw,
  input  logic [FLW-1:0] len,
  output logic           filt
);
  logic           st_q, st_n;
  logic [FLW-1:0] run_q, run_n;

  always_comb begin
    st_n  = st_q;
    run_n = run_q;
    if (raw == st_q) begin
      run_n = '0;
    end else if (run_q >= len) begin
      st_n  = raw;
      run_n = '0;
    end else begin
      run_n = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      run_q <= '0;
    end else begin
      st_q  <= st_n;
      run_q <= run_n;
    end
  end

  assign filt = st_q;
endmodule

// File: rtl/cpwm_fault.sv
module cpwm_fault #(
  parameter int NFLT = 4,
  parameter int FLW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] flt_in,
  input  logic [NFLT-1:0] flt_en,
  input  logic [NFLT-1:0] flt_lowact,
  input  logic [NFLT-1:0] flt_use_filt,
  input  logic [FLW-1:0]  flt_len,
  input  logic [1:0]      flt_mode,
  input  logic            wrap,
  input  logic            flt_clr,
  output logic            flag,
  output logic            shut_even,
  output logic            shut_odd
);
  import cpwm_pkg::*;

  fmode_e          mode;
  logic [NFLT-1:0] raw, filt, sel;
  logic            hit;
  logic            flag_q, flag_n, gate_q, gate_n;

  assign mode = fmode_e'(flt_mode);

  for (genvar i = 0; i < NFLT; i++) begin : g_in
    assign raw[i] = flt_en[i] & (flt_in[i] ^ flt_lowact[i]);
    cpwm_flt_filter #(.FLW(FLW)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw[i]),
      .len  (flt_len),
      .filt (filt[i])
    );
    assign sel[i] = flt_use_filt[i] ? filt[i] : raw[i];
  end

  assign hit = (|sel) && (mode != FM_OFF);

  always_comb begin
    flag_n = flag_q;
    if (hit)          flag_n = 1'b1;
    else if (flt_clr) flag_n = 1'b0;

    gate_n = gate_q;
    if (hit)                 gate_n = 1'b1;
    else if (mode == FM_OFF) gate_n = 1'b0;
    else if (wrap && (mode == FM_ALL_AUTO || !flag_q)) gate_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
      gate_q <= gate_n;
    end
  end

  assign flag      = flag_q;
  assign shut_even = (gate_q | hit) && (mode != FM_OFF);
  assign shut_odd  = (gate_q | hit) && (mode != FM_OFF) && (mode != FM_EVEN_MAN);
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int CW   = 16,
  parameter int DTW  = 10,
  parameter int NFLT = 4,
  parameter int FLW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cnt_val,
  input  logic [CW-1:0]   period,
  input  logic [CW-1:0]   duty,
  input  logic [1:0]      dt_pre,
  input  logic [DTW-1:0]  dt_cnt,
  input  logic [1:0]      out_lvl,
  input  logic            pair_inv,
  input  logic [1:0]      sw_en,
  input  logic [1:0]      sw_val,
  input  logic [1:0]      mask,
  input  logic [1:0]      flt_mode,
  input  logic [NFLT-1:0] flt_en,
  input  logic [NFLT-1:0] flt_lowact,
  input  logic [NFLT-1:0] flt_use_filt,
  input  logic [FLW-1:0]  flt_len,
  input  logic [NFLT-1:0] flt_in,
  input  logic            flt_clr,
  output logic            pin_hi,
  output logic            pin_lo,
  output logic            fault_flag
);
  import cpwm_pkg::*;
  localparam int NCH = 2;

  logic           ref_raw, wrap;
  logic           act_a, act_b;
  logic           shut_even, shut_odd;
  logic [NCH-1:0] chan, shut, pin_n, pin_q;
  lvl_e           lvl;

  assign ref_raw = cnt_val < duty;
  assign wrap    = cnt_val == (period - CW'(1));
  assign lvl     = lvl_e'(out_lvl);

  cpwm_deadtime #(.DTW(DTW)) dt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_in(ref_raw),
    .dt_pre(dt_pre),
    .dt_cnt(dt_cnt),
    .act_a (act_a),
    .act_b (act_b)
  );

  cpwm_fault #(.NFLT(NFLT), .FLW(FLW)) flt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_in      (flt_in),
    .flt_en      (flt_en),
    .flt_lowact  (flt_lowact),
    .flt_use_filt(flt_use_filt),
    .flt_len     (flt_len),
    .flt_mode    (flt_mode),
    .wrap        (wrap),
    .flt_clr     (flt_clr),
    .flag        (fault_flag),
    .shut_even   (shut_even),
    .shut_odd    (shut_odd)
  );

  assign chan[0] = pair_inv ? act_b : act_a;
  assign chan[1] = pair_inv ? act_a : act_b;
  assign shut[0] = shut_even;
  assign shut[1] = shut_odd;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_v, act_v;
    always_comb begin
      sel_v = sw_en[i] ? sw_val[i] : chan[i];
      act_v = sel_v & ~mask[i] & ~shut[i];
      case (lvl)
        LVL_HIGH: pin_n[i] = act_v;
        LVL_LOW:  pin_n[i] = ~act_v;
        default:  pin_n[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_n;
  end

  assign pin_hi = pin_q[0];
  assign pin_lo = pin_q[1];
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
  parameter int NFLT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      out_lvl,
  input logic [1:0]      sw_en,
  input logic [1:0]      mask,
  input logic [1:0]      flt_mode,
  input logic [NFLT-1:0] flt_en,
  input logic [NFLT-1:0] flt_lowact,
  input logic [NFLT-1:0] flt_use_filt,
  input logic [NFLT-1:0] flt_in,
  input logic            flt_clr,
  input logic            pin_hi,
  input logic            pin_lo,
  input logic            fault_flag
);
  logic f0_direct;
  assign f0_direct = flt_en[0] && !flt_use_filt[0] && (flt_in[0] != flt_lowact[0]);

  // R3: complementary pins never overlap in high-true operation
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_lvl) == 2'd2 && $past(sw_en) == 2'b00) |-> !(pin_hi && pin_lo));

  // R5: level off keeps both pins low
  p_off_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_lvl) == 2'd0) |-> (!pin_hi && !pin_lo));

  // R8: masked channel 0 inactive in high-true operation
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask[0]) && $past(out_lvl) == 2'd2) |-> !pin_hi);

  // R9: direct fault sets the flag
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (f0_direct && flt_mode != 2'd0) |=> fault_flag);

  // R9: direct fault in manual all-channel mode blanks both pins
  p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (f0_direct && flt_mode == 2'd2 && out_lvl == 2'd2) |=> (!pin_hi && !pin_lo));

  // R9: flag sticks until a clear request
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flt_clr) |=> fault_flag);
endmodule

bind cpwm_pair cpwm_pair_chk #(.NFLT(NFLT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_lvl     (out_lvl),
  .sw_en       (sw_en),
  .mask        (mask),
  .flt_mode    (flt_mode),
  .flt_en      (flt_en),
  .flt_lowact  (flt_lowact),
  .flt_use_filt(flt_use_filt),
  .flt_in      (flt_in),
  .flt_clr     (flt_clr),
  .pin_hi      (pin_hi),
  .pin_lo      (pin_lo),
  .fault_flag  (fault_flag)
);

// File: tb/cpwm_pair_tb.sv
`timescale 1ns/1ps
module cpwm_pair_tb_top;
  localparam int CW = 16, DTW = 10, NFLT = 4, FLW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [CW-1:0]   cnt_val, period, duty;
  logic [1:0]      dt_pre, out_lvl, sw_en, sw_val, mask, flt_mode;
  logic [DTW-1:0]  dt_cnt;
  logic            pair_inv, flt_clr;
  logic [NFLT-1:0] flt_en, flt_lowact, flt_use_filt, flt_in;
  logic [FLW-1:0]  flt_len;
  logic            pin_hi, pin_lo, fault_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  int hi_n, lo_n, both_n;

  always #2 clk = ~clk;

  cpwm_pair #(.CW(CW), .DTW(DTW), .NFLT(NFLT), .FLW(FLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .period(period), .duty(duty),
    .dt_pre(dt_pre), .dt_cnt(dt_cnt), .out_lvl(out_lvl), .pair_inv(pair_inv),
    .sw_en(sw_en), .sw_val(sw_val), .mask(mask), .flt_mode(flt_mode),
    .flt_en(flt_en), .flt_lowact(flt_lowact), .flt_use_filt(flt_use_filt),
    .flt_len(flt_len), .flt_in(flt_in), .flt_clr(flt_clr),
    .pin_hi(pin_hi), .pin_lo(pin_lo), .fault_flag(fault_flag));

  initial begin
    cnt_val = '0;
    forever begin
      @(negedge clk);
      if (!rst_n || cnt_val >= period - 1) cnt_val = '0;
      else cnt_val = cnt_val + 1'b1;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    hi_n = 0; lo_n = 0; both_n = 0;
    repeat (n) begin
      @(negedge clk);
      hi_n += int'(pin_hi);
      lo_n += int'(pin_lo);
      both_n += int'(pin_hi && pin_lo);
    end
  endtask

  task automatic set_pwm(input int p, input int d, input int pre, input int dc);
    @(negedge clk);
    period = CW'(p); duty = CW'(d); dt_pre = 2'(pre); dt_cnt = DTW'(dc);
    idle(2 * p + 16 * dc + 4);
    measure(p);
  endtask

  task automatic defaults();
    @(negedge clk);
    out_lvl = 2'd2; pair_inv = 0; sw_en = 0; sw_val = 0; mask = 0;
    flt_mode = 2'd2; flt_en = 4'b0001; flt_lowact = 0; flt_use_filt = 0;
    flt_in = 0; flt_clr = 0; flt_len = 4'd5; dt_pre = 0; dt_cnt = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flt_clr = 1;
    @(negedge clk); flt_clr = 0;
  endtask

  task automatic t_reset();
    checks++;
    if (pin_hi || pin_lo || fault_flag) begin
      errors++;
      $display("FAIL reset: actual=%b%b%b expected=000", pin_hi, pin_lo, fault_flag);
    end
  endtask

  task automatic t_duty();
    set_pwm(20, 7, 0, 0);
    chk(hi_n, 7, "R1 hi count"); chk(lo_n, 13, "R1 lo count");
    set_pwm(20, 0, 0, 0);
    chk(hi_n, 0, "R2 duty0 hi"); chk(lo_n, 20, "R2 duty0 lo");
    set_pwm(20, 20, 0, 0);
    chk(hi_n, 20, "R2 full hi"); chk(lo_n, 0, "R2 full lo");
  endtask

  task automatic t_deadtime();
    set_pwm(20, 7, 0, 2);
    chk(hi_n, 5, "R3 x1 hi"); chk(lo_n, 11, "R3 x1 lo"); chk(both_n, 0, "R3 overlap");
    set_pwm(40, 20, 2, 1);
    chk(hi_n, 4, "R3 x16 hi"); chk(lo_n, 4, "R3 x16 lo");
    set_pwm(300, 150, 0, 100);
    chk(hi_n, 50, "R3 ext hi"); chk(lo_n, 50, "R3 ext lo");
    set_pwm(20, 7, 1, 2);
    chk(hi_n, 0, "R4 suppressed hi"); chk(lo_n, 5, "R4 lo after gap");
    set_pwm(20, 7, 0, 0);
  endtask

  task automatic t_level();
    @(negedge clk); out_lvl = 2'd1; measure(20);
    chk(hi_n, 13, "R5 low-true hi"); chk(lo_n, 7, "R5 low-true lo");
    @(negedge clk); out_lvl = 2'd0; measure(20);
    chk(hi_n + lo_n, 0, "R5 off");
    @(negedge clk); out_lvl = 2'd2; idle(2);
  endtask

  task automatic t_inv_sw_mask();
    @(negedge clk); pair_inv = 1; idle(2); measure(20);
    chk(hi_n, 13, "R6 inv hi"); chk(lo_n, 7, "R6 inv lo");
    @(negedge clk); pair_inv = 0; sw_en = 2'b01; sw_val = 2'b01; idle(2); measure(20);
    chk(hi_n, 20, "R7 sw hi"); chk(lo_n, 13, "R7 lo normal");
    @(negedge clk); mask = 2'b01; idle(2); measure(20);
    chk(hi_n, 0, "R8 mask over sw");
    @(negedge clk); out_lvl = 2'd1; idle(2); measure(20);
    chk(hi_n, 20, "R8 mask low-true");
    @(negedge clk); out_lvl = 2'd2; mask = 0; sw_en = 0; sw_val = 0; idle(2);
  endtask

  task automatic t_manual();
    @(negedge clk); flt_mode = 2'd2; flt_in[0] = 1; idle(3);
    chk(int'(fault_flag), 1, "R9 flag set");
    measure(20); chk(hi_n + lo_n, 0, "R9 shutdown");
    pulse_clr(); idle(1);
    chk(int'(fault_flag), 1, "R9 clear ignored during fault");
    @(negedge clk); flt_in[0] = 0; idle(45); measure(20);
    chk(hi_n + lo_n, 0, "R9 held until clear");
    pulse_clr(); idle(45); measure(20);
    chk(hi_n, 7, "R9 resume hi"); chk(lo_n, 13, "R9 resume lo");
    chk(int'(fault_flag), 0, "R9 flag cleared");
  endtask

  task automatic t_auto();
    @(negedge clk); flt_mode = 2'd3; flt_in[0] = 1; idle(3);
    measure(20); chk(hi_n + lo_n, 0, "R10 shutdown");
    @(negedge clk); flt_in[0] = 0; idle(45); measure(20);
    chk(hi_n, 7, "R10 auto resume hi"); chk(lo_n, 13, "R10 auto resume lo");
    chk(int'(fault_flag), 1, "R10 flag sticky");
    pulse_clr(); idle(2);
  endtask

  task automatic t_even();
    @(negedge clk); flt_mode = 2'd1; flt_in[0] = 1; idle(3); measure(20);
    chk(hi_n, 0, "R11 even off"); chk(lo_n, 13, "R11 odd runs");
    @(negedge clk); flt_in[0] = 0; pulse_clr(); idle(45);
  endtask

  task automatic t_disabled();
    @(negedge clk); flt_mode = 2'd0; flt_in[0] = 1; idle(3); measure(20);
    chk(hi_n, 7, "R12 mode0 hi"); chk(int'(fault_flag), 0, "R12 mode0 flag");
    @(negedge clk); flt_mode = 2'd2; flt_en = 0; idle(3); measure(20);
    chk(lo_n, 13, "R12 en off lo"); chk(int'(fault_flag), 0, "R12 en off flag");
    @(negedge clk); flt_in[0] = 0; flt_en = 4'b0001; idle(2);
  endtask

  task automatic t_polarity();
    @(negedge clk); flt_lowact[0] = 1; flt_in[0] = 1; idle(5);
    chk(int'(fault_flag), 0, "R13 high is idle");
    @(negedge clk); flt_in[0] = 0; idle(3);
    chk(int'(fault_flag), 1, "R13 low is fault");
    @(negedge clk); flt_lowact[0] = 0; pulse_clr(); idle(45); measure(20);
    chk(hi_n, 7, "R13 resume");
  endtask

  task automatic t_filter();
    @(negedge clk); flt_use_filt[0] = 1; flt_len = 4'd5; flt_in[0] = 1;
    idle(3);
    @(negedge clk); flt_in[0] = 0; idle(10);
    chk(int'(fault_flag), 0, "R14 glitch rejected");
    @(negedge clk); flt_in[0] = 1; idle(12);
    chk(int'(fault_flag), 1, "R14 long fault seen");
    @(negedge clk); flt_in[0] = 0; idle(10); pulse_clr(); idle(45); measure(20);
    chk(hi_n, 7, "R14 resume");
  endtask

  initial begin
    rst_n = 0;
    period = 20; duty = 7;
    defaults();
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_duty();
    t_deadtime();
    t_level();
    t_inv_sw_mask();
    t_manual();
    t_auto();
    t_even();
    t_disabled();
    t_polarity();
    t_filter();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule